// File: doc/BRIEF.md
# UART Autobaud Rate Detector

This block works out the bit rate of a UART link from the first start bit that arrives on the receive line. Software arms it through one enable bit. Once armed, the block waits for the line to fall and counts 16x oversample enables until the line rises again. It turns that width into a divisor for the baud rate generator and writes the divisor out with a one-cycle strobe.

The enable bit clears by itself at the end of a measurement, whether the measurement succeeds or fails. Software can set or clear the bit only under guard conditions that depend on whether the UART is on and whether the receiver is idle. Turning the UART off always drops the bit. A start bit that is too short, or a low level that outlasts the counter, raises a sticky error flag. In that case the divisor output is not changed.

Receiving characters after the measurement is outside this block, and so is the baud generator.

Top module: `autobaud_det`

## Requirements
- R1: After reset, ab_armed, ab_err, ab_done and div_we are 0, and div_val is 0.
- R2: A write of 1 (en_wr=1, en_wdata=1) sets ab_armed on the next clock edge only if uart_en=1 and rx_idle=1 in that cycle. Otherwise the write is ignored and ab_armed stays 0.
- R3: A write of 0 (en_wr=1, en_wdata=0) clears ab_armed on the next edge only if rx_idle=1. With rx_idle=0 the write is ignored and ab_armed stays 1.
- R4: uart_en=0 clears ab_armed on the next edge, whatever else happens in that cycle.
- R5: Inputs are looked at only in cycles with samp_tick=1. While the block is armed, a tick with rx_sync=0 that follows a tick with rx_sync=1 starts a count at 1. Each later low tick adds 1. On the first high tick the count N ends, and if N is at least 16, div_val becomes floor(N/16)-1 and div_we and ab_done pulse high for one cycle, one edge after that tick.
- R6: One edge after ab_done, ab_armed is 0.
- R7: If N is below 16, ab_err and ab_done are set one edge after the ending tick. div_we stays 0 and div_val keeps its previous value.
- R8: The counter is 12 bits wide. If rx_sync is still low on the tick after the count has reached 4095, the measurement fails as in R7. A pulse of exactly 4095 low ticks is valid and gives a divisor of 254.
- R9: ab_err stays 1 until a cycle with err_clr=1, and it reads 0 after that edge.
- R10: While ab_armed is 0, pulses on rx_sync produce no div_we and no ab_done, and div_val does not change.
- R11: A low level on rx_sync that occurs only in cycles with samp_tick=0 does not start a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the autobaud enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| uart_en | input | 1 | UART enabled |
| rx_idle | input | 1 | Receiver idle |
| rx_sync | input | 1 | Synchronized receive line |
| samp_tick | input | 1 | 16x oversample clock enable |
| div_we | output | 1 | Divisor write strobe |
| div_val | output | 8 | Divisor value |
| ab_armed | output | 1 | Autobaud enable bit |
| ab_done | output | 1 | Measurement finished pulse (success or error) |
| ab_err | output | 1 | Sticky autobaud error |

## Verification
A change to the enable bit appears one edge after the write or after uart_en falls. A measurement result (divisor strobe, or done together with error) appears one edge after the tick that sees the line high again or that finds the counter saturated, and the enable bit drops one edge after that. A driver task queues the expected result whenever it sends a pulse. A monitor running on the falling clock edge pops the queue only in the cycle where ab_done is high, so any result that comes early, late or without being expected shows up as a mismatch. Level checks on ab_armed, div_val and ab_err are made at falling edges a few cycles after each stimulus, when the value has settled.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_MEAS,
        ST_HOLD
    } meter_st_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_SHORT,
        RES_SAT
    } res_kind_e;

    function automatic logic [31:0] div_of(logic [31:0] cnt, int unsigned lg);
        return (cnt >> lg) - 32'd1;
    endfunction

endpackage

// File: rtl/abr_ctrl.sv
module abr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic uart_en,
    input  logic rx_idle,
    input  logic done_i,
    output logic armed_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!uart_en || done_i) begin
            armed_q <= 1'b0;
        end else if (en_wr) begin
            if (en_wdata && rx_idle)
                armed_q <= 1'b1;
            else if (!en_wdata && rx_idle)
                armed_q <= 1'b0;
        end
    end

    assign armed_o = armed_q;

    // R2
    arm_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> $past(en_wr && en_wdata && uart_en && rx_idle));
    // R3
    clr_guard_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(armed_q) && $past(uart_en && !done_i)) |-> $past(rx_idle && en_wr));
    // R4
    uart_off_chk: assert property (@(posedge clk) disable iff (rst)
        !uart_en |=> !armed_q);
    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !armed_q);

endmodule

// File: rtl/abr_meter.sv
module abr_meter
    import abr_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int MIN_SAMP = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             tick,
    input  logic             rx,
    output res_kind_e        kind_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_SAMP);

    meter_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rx_q;
    res_kind_e        kind_c;

    always_comb begin
        kind_c = RES_NONE;
        if (armed && tick && st_q == ST_MEAS) begin
            if (!rx) begin
                if (cnt_q == CNT_MAX)
                    kind_c = RES_SAT;
            end else begin
                kind_c = (cnt_q < CNT_MIN) ? RES_SHORT : RES_OK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= 1'b1;
        end else if (tick) begin
            rx_q <= rx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
        end else if (tick) begin
            case (st_q)
                ST_WAIT: begin
                    if (rx_q && !rx) begin
                        st_q  <= ST_MEAS;
                        cnt_q <= CNT_W'(1);
                    end
                end
                ST_MEAS: begin
                    if (kind_c != RES_NONE)
                        st_q <= ST_HOLD;
                    else if (!rx)
                        cnt_q <= cnt_q + CNT_W'(1);
                end
                default: st_q <= ST_HOLD;
            endcase
        end
    end

    assign kind_o = kind_c;
    assign cnt_o  = cnt_q;

    // R5
    meas_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MEAS) |-> (cnt_q != '0));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (st_q == ST_WAIT));

endmodule

// File: rtl/abr_result.sv
module abr_result
    import abr_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OVS   = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  res_kind_e                      kind,
    input  logic [CNT_W-1:0]               cnt,
    input  logic                           err_clr,
    output logic                           div_we,
    output logic [CNT_W-$clog2(OVS)-1:0]   div_val,
    output logic                           done,
    output logic                           err
);
    localparam int OVS_LG = $clog2(OVS);
    localparam int DIV_W  = CNT_W - OVS_LG;

    logic [DIV_W-1:0] div_q;
    logic             we_q;
    logic             done_q;
    logic             err_q;
    logic             bad;

    assign bad = (kind == RES_SHORT) || (kind == RES_SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            we_q   <= (kind == RES_OK);
            done_q <= (kind != RES_NONE);
            if (kind == RES_OK)
                div_q <= DIV_W'(div_of(32'(cnt), OVS_LG));
            if (bad)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    assign div_we  = we_q;
    assign div_val = div_q;
    assign done    = done_q;
    assign err     = err_q;

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> we_q);
    // R7
    we_not_err_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |-> ($past(err_q) == err_q || !err_q));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);
    // R5
    we_done_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |-> done_q);

endmodule

// File: rtl/autobaud_det.sv
module autobaud_det
    import abr_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int OVS      = 16,
    parameter int MIN_SAMP = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en_wr,
    input  logic                         en_wdata,
    input  logic                         err_clr,
    input  logic                         uart_en,
    input  logic                         rx_idle,
    input  logic                         rx_sync,
    input  logic                         samp_tick,
    output logic                         div_we,
    output logic [CNT_W-$clog2(OVS)-1:0] div_val,
    output logic                         ab_armed,
    output logic                         ab_done,
    output logic                         ab_err
);
    res_kind_e        kind;
    logic [CNT_W-1:0] cnt;

    abr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (en_wr),
        .en_wdata(en_wdata),
        .uart_en (uart_en),
        .rx_idle (rx_idle),
        .done_i  (ab_done),
        .armed_o (ab_armed)
    );

    abr_meter #(.CNT_W(CNT_W), .MIN_SAMP(MIN_SAMP)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .armed (ab_armed),
        .tick  (samp_tick),
        .rx    (rx_sync),
        .kind_o(kind),
        .cnt_o (cnt)
    );

    abr_result #(.CNT_W(CNT_W), .OVS(OVS)) u_res (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .cnt    (cnt),
        .err_clr(err_clr),
        .div_we (div_we),
        .div_val(div_val),
        .done   (ab_done),
        .err    (ab_err)
    );

endmodule

// File: tb/sim_autobaud_det.sv
`timescale 1ns/1ps
module sim_autobaud_det;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_wr = 1'b0, en_wdata = 1'b0, err_clr = 1'b0;
    logic uart_en = 1'b1, rx_idle = 1'b1, rx_sync = 1'b1, samp_tick = 1'b0;
    logic       div_we, ab_armed, ab_done, ab_err;
    logic [7:0] div_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        bit is_err;
        int dv;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    autobaud_det u0 (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .err_clr(err_clr), .uart_en(uart_en), .rx_idle(rx_idle),
        .rx_sync(rx_sync), .samp_tick(samp_tick), .div_we(div_we),
        .div_val(div_val), .ab_armed(ab_armed), .ab_done(ab_done),
        .ab_err(ab_err)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(bit v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic tick(bit v);
        @(negedge clk);
        rx_sync = v; samp_tick = 1'b1;
        @(negedge clk);
        samp_tick = 1'b0;
    endtask

    task automatic pulse(int n, bit expect_res);
        tick(1'b1);
        if (expect_res) begin
            exp_t e;
            e.is_err = (n < 16) || (n > 4095);
            e.dv = (n / 16) - 1;
            q.push_back(e);
        end
        for (int i = 0; i < n; i++) tick(1'b0);
        tick(1'b1);
        idle(4);
    endtask

    // monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (!rst && !finished && ab_done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.is_err) begin
                    chk(ab_err == 1'b1, "R7/R8 err on completion", int'(ab_err), 1);
                    chk(div_we == 1'b0, "R7 no div_we on error", int'(div_we), 0);
                end else begin
                    chk(div_we == 1'b1, "R5 div_we with done", int'(div_we), 1);
                    chk(int'(div_val) == e.dv, "R5 divisor value", int'(div_val), e.dv);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(ab_armed == 0, "R1 armed", int'(ab_armed), 0);
        chk(ab_err == 0, "R1 err", int'(ab_err), 0);
        chk(div_val == 0, "R1 div", int'(div_val), 0);
        chk(div_we == 0 && ab_done == 0, "R1 strobes", int'(div_we | ab_done), 0);

        // R2 guarded set
        uart_en = 1'b0; wr_en(1'b1); uart_en = 1'b1; idle(1);
        chk(ab_armed == 0, "R2 set ignored uart off", int'(ab_armed), 0);
        rx_idle = 1'b0; wr_en(1'b1); rx_idle = 1'b1; idle(1);
        chk(ab_armed == 0, "R2 set ignored rx busy", int'(ab_armed), 0);
        wr_en(1'b1);
        chk(ab_armed == 1, "R2 set accepted", int'(ab_armed), 1);

        // R11 low between ticks only
        @(negedge clk); rx_sync = 1'b0;
        @(negedge clk); rx_sync = 1'b1;
        tick(1'b1); idle(3);
        chk(ab_armed == 1, "R11 no measurement", int'(ab_armed), 1);

        // R5 / R6 normal
        pulse(160, 1'b1);
        chk(ab_armed == 0, "R6 armed cleared", int'(ab_armed), 0);

        // R10 disarmed pulse
        pulse(64, 1'b0);
        chk(div_val == 9, "R10 div unchanged", int'(div_val), 9);

        // R7 short pulse
        wr_en(1'b1);
        pulse(15, 1'b1);
        chk(div_val == 9, "R7 div kept", int'(div_val), 9);
        chk(ab_armed == 0, "R7 armed cleared", int'(ab_armed), 0);
        idle(5);
        chk(ab_err == 1, "R9 err sticky", int'(ab_err), 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(ab_err == 0, "R9 err cleared", int'(ab_err), 0);

        // R5 boundary 16
        wr_en(1'b1);
        pulse(16, 1'b1);
        chk(div_val == 0, "R5 min width divisor", int'(div_val), 0);

        // R8 largest valid
        wr_en(1'b1);
        pulse(4095, 1'b1);
        chk(div_val == 254, "R8 max width divisor", int'(div_val), 254);

        // R8 saturation
        wr_en(1'b1);
        pulse(4096, 1'b1);
        chk(ab_err == 1, "R8 saturation err", int'(ab_err), 1);
        chk(div_val == 254, "R8 div kept", int'(div_val), 254);
        chk(ab_armed == 0, "R8 armed cleared", int'(ab_armed), 0);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;

        // R3 guarded clear
        wr_en(1'b1);
        rx_idle = 1'b0; wr_en(1'b0); rx_idle = 1'b1; idle(1);
        chk(ab_armed == 1, "R3 clear ignored rx busy", int'(ab_armed), 1);
        wr_en(1'b0);
        chk(ab_armed == 0, "R3 clear accepted", int'(ab_armed), 0);

        // R4 uart off
        wr_en(1'b1);
        chk(ab_armed == 1, "R4 rearmed", int'(ab_armed), 1);
        @(negedge clk); uart_en = 1'b0;
        @(negedge clk); uart_en = 1'b1;
        chk(ab_armed == 0, "R4 uart off clears", int'(ab_armed), 0);

        idle(4);
        chk(q.size() == 0, "R5 all results seen", q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule